// File: doc/BRIEF.md
# Down-Counting Match-Compare Timer Channel

A single timer channel with a 32-bit counter that only ever counts down, one step per pulse of a selected tick line. In match mode the counter runs freely through the whole 32-bit range, wrapping from zero to all ones. A sticky event flag is raised when a tick moves the count onto the value held in the match register. Software schedules each next event by moving the match register further down. With match mode off, the counter stops at zero. It can optionally reload a fixed value on the tick after it reaches zero, which gives a periodic countdown. Without reload, a write to the count starts a one-shot countdown.

All state is reached through a small single-cycle register bus. Every register has a plain address, a set alias (plain + 0x4) that ORs the written data in, and a clear alias (plain + 0x8) that clears the written ones. This lets single control bits change without a read-modify-write. A block-level soft-reset bit zeroes the channel and holds it idle. The interrupt output is the event flag gated by the interrupt enable.

Top module: `dctimer`

## Requirements
- R1: After rst_n is released, every register reads 0 and irq is low.
- R2: The count changes only on a cycle where tick_in[sel] is high, where sel is control bits [3:0], or on a count write. Pulses on any other tick line have no effect.
- R3: In match mode (control bit 11 = 1), each selected tick decrements the count by one. The count wraps from 0 to 0xFFFFFFFF. The event flag is raised when a tick makes the count equal the match register, so a match set d below the count fires on the d-th tick.
- R4: With match mode off and reload (bit 6) off, writing N to the count raises the flag on the N-th tick. The count then stays at 0 and raises no further event.
- R5: With match mode off and reload on, a tick seen while the count is 0 loads the fixed reload value RELOAD_VAL. Counting then continues down, and the flag is raised again on reaching 0.
- R6: For every register, a write to the address + 0x4 ORs wdata into it, and a write to the address + 0x8 clears the bits set in wdata.
- R7: The event flag (control bit 15) stays set until it is cleared by a write. If an event and a clear arrive in the same cycle, the flag ends up set.
- R8: irq is high exactly when the flag and the interrupt enable (control bit 14) are both set.
- R9: Bit 31 of the block register at 0x00 is the soft reset. While it is 1, the control, count and match registers read 0, writes to them are ignored, and ticks do nothing.
- R10: With update (control bit 7) set, a count write is held and loaded on the next selected tick, which does not decrement. Reads always return the live count.
- R11: The register map is: control at 0x20, count at 0x30, match at 0x50. Control bits other than [3:0], 6, 7, 11, 14 and 15 read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick_in | input | 16 | One-cycle tick enables, one per source |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
Match mode is swept over deltas 1 to 8 below a running count. The irq must stay low for d-1 ticks and rise on the d-th, which separates an off-by-one compare from a correct one. A case just above zero whose match lies past the wrap checks the free-running range. One-shot countdowns from 1 to 6 are checked, followed by idle ticks, to show that the count stays at zero and raises no second event. A reload run separates the stop-at-zero behaviour from the periodic one. Each of the 16 select values is driven against pulses on every other tick line, proving that only the chosen line moves the count. Further cases cover the alias arithmetic, the deferred update, an event arriving with a clear, and soft reset.

// File: rtl/dctimer.sv
`timescale 1ns/1ps
module dctimer #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NTICK = 16,
  parameter logic [DW-1:0] RELOAD_VAL = 'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NTICK-1:0] tick_in,
  output logic          irq
);
  localparam int SW = $clog2(NTICK);
  localparam logic [AW-1:0] A_BLK = 'h00, A_CTL = 'h20, A_CNT = 'h30, A_MAT = 'h50;
  localparam logic [DW-1:0] CTL_MASK = (DW'(1) << 15) | (DW'(1) << 14) | (DW'(1) << 11)
                                     | (DW'(1) << 7) | (DW'(1) << 6) | DW'(NTICK - 1);

  function automatic logic [DW-1:0] apply(input logic [1:0] op, input logic [DW-1:0] cur, wd);
    case (op)
      2'd1:    return cur | wd;
      2'd2:    return cur & ~wd;
      default: return wd;
    endcase
  endfunction

  logic          srst, pend_v;
  logic [DW-1:0] ctl, cnt, mat, pend;

  wire [1:0]    op     = bus_addr[3:2];
  wire          wr_ok  = bus_we && bus_addr[1:0] == 2'b00 && op != 2'b11;
  wire [AW-1:0] base   = {bus_addr[AW-1:4], 4'h0};
  wire          wr_blk = wr_ok && base == A_BLK;
  wire          wr_ctl = wr_ok && base == A_CTL && !srst;
  wire          wr_cnt = wr_ok && base == A_CNT && !srst;
  wire          wr_mat = wr_ok && base == A_MAT && !srst;

  wire          mm   = ctl[11];
  wire          rld  = ctl[6];
  wire          upd  = ctl[7];
  wire          tick = tick_in[ctl[SW-1:0]] && !srst;
  wire [DW-1:0] dec  = cnt - 1'b1;
  wire          cnt_now = wr_cnt && !upd;
  wire          evt  = tick && !pend_v && !cnt_now && (mm ? dec == mat : cnt == DW'(1));
  wire [DW-1:0] blk_nxt = apply(op, {srst, {(DW-1){1'b0}}}, bus_wdata);
  wire [DW-1:0] ctl_wr  = (wr_ctl ? apply(op, ctl, bus_wdata) : ctl) & CTL_MASK;

  assign irq = ctl[15] & ctl[14];

  always_comb begin
    case (base)
      A_BLK:   bus_rdata = {srst, {(DW-1){1'b0}}};
      A_CTL:   bus_rdata = ctl;
      A_CNT:   bus_rdata = cnt;
      A_MAT:   bus_rdata = mat;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= 1'b0;
    end else if (wr_blk) begin
      srst <= blk_nxt[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      mat <= '0;
    end else if (srst) begin
      ctl <= '0;
      mat <= '0;
    end else begin
      ctl <= ctl_wr | (DW'(evt) << 15);
      if (wr_mat) mat <= apply(op, mat, bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (srst) begin
      cnt    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else begin
      if (cnt_now)                  cnt <= apply(op, cnt, bus_wdata);
      else if (tick && pend_v)      cnt <= pend;
      else if (tick && (mm || cnt != '0)) cnt <= dec;
      else if (tick && rld)         cnt <= RELOAD_VAL;
      if (wr_cnt && upd) begin
        pend   <= apply(op, cnt, bus_wdata);
        pend_v <= 1'b1;
      end else if (tick) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dctimer_chk.sv
`timescale 1ns/1ps
module dctimer_chk #(
  parameter int DW = 32,
  parameter logic [DW-1:0] RELOAD_VAL = 'hFFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          tick,
  input logic          wr_cnt,
  input logic          wr_ctl,
  input logic          pend_v,
  input logic          mm,
  input logic          rld,
  input logic          flag,
  input logic          ie,
  input logic          irq,
  input logic [DW-1:0] cnt
);
  p_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_cnt && !srst |=> $stable(cnt));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mm && !pend_v && !wr_cnt |=> cnt == $past(cnt) - 1'b1);
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !srst && !mm && !rld && !pend_v && !wr_cnt && cnt == '0 |=> cnt == '0);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !mm && rld && !pend_v && !wr_cnt && cnt == '0 |=> cnt == RELOAD_VAL);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_ctl && !srst |=> flag);
  p_irq_ie_r8: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ie);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n) !flag |-> !irq);
  p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> cnt == '0 && !flag && !pend_v);
endmodule

bind dctimer dctimer_chk #(.DW(DW), .RELOAD_VAL(RELOAD_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick), .wr_cnt(wr_cnt),
  .wr_ctl(wr_ctl), .pend_v(pend_v), .mm(mm), .rld(rld), .flag(ctl[15]),
  .ie(ctl[14]), .irq(irq), .cnt(cnt)
);

// File: tb/dctimer_bench.sv
`timescale 1ns/1ps
module dctimer_bench;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] tick_in = 0;
  logic        irq;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] v;

  localparam logic [31:0] MM = 32'h800, IE = 32'h4000, FLAG = 32'h8000;
  localparam logic [31:0] RLD = 32'h40, UPD = 32'h80, SEL = 32'hB;

  always #2 clk = ~clk;

  dctimer #(.RELOAD_VAL(32'd5)) u_dctimer (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .tick_in(tick_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tk(input int idx);
    @(negedge clk); tick_in = 16'(1) << idx;
    @(negedge clk); tick_in = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (v[i]) ; // no-op keeps v declared use
    rd(8'h00, v); chk("R1 blk", v, 0);
    rd(8'h20, v); chk("R1 ctl", v, 0);
    rd(8'h30, v); chk("R1 cnt", v, 0);
    rd(8'h50, v); chk("R1 mat", v, 0);
    chk("R1 irq", irq, 0);

    // R11 control mask and unmapped read
    wr(8'h20, 32'hFFFF_FFFF & ~FLAG);
    rd(8'h20, v); chk("R11 ctl mask", v, 32'h0000_48CF);
    rd(8'h40, v); chk("R11 unmapped", v, 0);

    // R3 match sweep
    wr(8'h20, SEL | MM | IE);
    for (int d = 1; d <= 8; d++) begin
      wr(8'h30, 32'd100);
      wr(8'h50, 32'd100 - d);
      for (int i = 0; i < d - 1; i++) tk(11);
      chk($sformatf("R3 no early irq d=%0d", d), irq, 0);
      tk(11);
      chk($sformatf("R3 irq on tick d=%0d", d), irq, 1);
      rd(8'h30, v); chk("R3 count", v, 32'd100 - d);
      tk(11); tk(11);
      chk("R7 sticky", irq, 1);
      wr(8'h28, FLAG);
      chk("R7 cleared", irq, 0);
    end
    // R3 wrap
    wr(8'h30, 32'd2);
    wr(8'h50, 32'hFFFF_FFFE);
    for (int i = 0; i < 3; i++) tk(11);
    chk("R3 wrap no early", irq, 0);
    tk(11);
    chk("R3 wrap irq", irq, 1);
    rd(8'h30, v); chk("R3 wrap count", v, 32'hFFFF_FFFE);
    wr(8'h28, FLAG);

    // R7 event beats clear in the same cycle
    wr(8'h30, 32'd10);
    wr(8'h50, 32'd9);
    @(negedge clk); we = 1; addr = 8'h28; wdata = FLAG; tick_in = 16'h0800;
    @(negedge clk); we = 0; tick_in = 0;
    chk("R7 event over clear", irq, 1);
    // R8 enable gating
    wr(8'h28, IE);
    chk("R8 ie off", irq, 0);
    rd(8'h20, v); chk("R8 flag kept", v & FLAG, FLAG);
    wr(8'h24, IE);
    chk("R8 ie on", irq, 1);
    wr(8'h28, FLAG);

    // R2 tick select sweep
    for (int s = 0; s < 16; s++) begin
      wr(8'h20, MM | 32'(s));
      wr(8'h30, 32'd1000);
      for (int o = 0; o < 16; o++) if (o != s) tk(o);
      rd(8'h30, v); chk($sformatf("R2 others ignored sel=%0d", s), v, 32'd1000);
      tk(s);
      rd(8'h30, v); chk($sformatf("R2 selected sel=%0d", s), v, 32'd999);
    end

    // R4 one-shot sweep
    wr(8'h20, SEL | IE);
    for (int n = 1; n <= 6; n++) begin
      wr(8'h30, 32'(n));
      for (int i = 0; i < n - 1; i++) tk(11);
      chk($sformatf("R4 no early n=%0d", n), irq, 0);
      tk(11);
      chk($sformatf("R4 fire n=%0d", n), irq, 1);
      wr(8'h28, FLAG);
      tk(11); tk(11);
      rd(8'h30, v); chk("R4 stays zero", v, 0);
      chk("R4 no refire", irq, 0);
    end

    // R5 reload
    wr(8'h24, RLD);
    wr(8'h30, 32'd2);
    tk(11); tk(11);
    chk("R5 first zero", irq, 1);
    wr(8'h28, FLAG);
    tk(11);
    rd(8'h30, v); chk("R5 reload value", v, 32'd5);
    for (int i = 0; i < 4; i++) tk(11);
    chk("R5 no early", irq, 0);
    tk(11);
    chk("R5 refire", irq, 1);
    wr(8'h28, FLAG | RLD);

    // R10 deferred update
    wr(8'h30, 32'd20);
    wr(8'h24, UPD);
    wr(8'h30, 32'd50);
    rd(8'h30, v); chk("R10 live before tick", v, 32'd20);
    tk(11);
    rd(8'h30, v); chk("R10 loaded on tick", v, 32'd50);
    tk(11);
    rd(8'h30, v); chk("R10 then decrements", v, 32'd49);
    wr(8'h28, UPD);

    // R6 aliases
    wr(8'h50, 32'h0000_00F0);
    wr(8'h54, 32'h0000_000F);
    rd(8'h50, v); chk("R6 set alias", v, 32'h0000_00FF);
    wr(8'h58, 32'h0000_00F0);
    rd(8'h50, v); chk("R6 clear alias", v, 32'h0000_000F);
    wr(8'h34, 32'h0000_0100);
    rd(8'h30, v); chk("R6 set on count", v, 32'd49 | 32'h100);

    // R9 soft reset
    wr(8'h04, 32'h8000_0000);
    rd(8'h00, v); chk("R9 bit set", v, 32'h8000_0000);
    rd(8'h20, v); chk("R9 ctl zero", v, 0);
    rd(8'h30, v); chk("R9 cnt zero", v, 0);
    rd(8'h50, v); chk("R9 mat zero", v, 0);
    wr(8'h30, 32'd77);
    rd(8'h30, v); chk("R9 write ignored", v, 0);
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, v); chk("R9 released", v, 0);
    wr(8'h30, 32'd77);
    rd(8'h30, v); chk("R9 write after release", v, 32'd77);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule